// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN protocol controller is in, and what that mode allows. Software asks for halt or sleep through two request inputs. The bit-level engine reports three things: whether the bus is idle, whether it is in the inter-frame gap, and each sampled bit together with a strobe. The sequencer defers halt and sleep entry until the bus reaches a point where leaving it is safe. It holds the controller off the bus while halted or asleep. After any release, the controller takes part in bus traffic again only when it has seen a full run of recessive bits.

While asleep, the sequencer drops the clock enable of the main controller logic. It also gates register access, so that only a small always-on group of registers stays reachable. Reads of any other register return zero, writes to them are dropped, and a one-cycle error pulse follows each such access. The transmit and receive flag registers are therefore out of reach during sleep, and software must clear them beforehand.

Top module: `can_mode_seq`

## Requirements
- R1: While in normal mode (mode 00), a raised halt request moves the mode to halted (10) at the first clock edge at which bus idle or intermission is high, or at which the controller has not yet joined the bus. Until then the mode reads halt-pending (01) and bus participation stays on.
- R2: The halt status output is high exactly while the mode reads halted (10). Mode codes are 00 normal, 01 pending, 10 halted, 11 sleep, and the mode is 00 after reset.
- R3: Bus participation is low whenever the mode is halted or sleep.
- R4: Dropping the halt request while halted returns the mode to 00 on the same edge at which halt status clears. Bus participation then rises only after 11 consecutive bit strobes that sample a recessive bit (rx_bit = 1). A strobe with a dominant bit restarts the count. The same wait applies after reset.
- R5: A sleep request while halted enters sleep (11) on the next edge. From normal, sleep follows the same safe-point rule as halt. When both requests are raised, sleep takes priority.
- R6: In sleep the core clock enable is low. Releasing sleep goes to halted if a halt request is present, and otherwise to normal with the recessive-run wait of R4.
- R7: In sleep, an access to any register index other than 0 to 3 suppresses the read and write enables and returns zero read data. The access error output then pulses high one cycle later. Indices 0 to 3 (mode control, global status, interrupt request, interrupt mask) pass untouched. Indices 4 to 7 hold the transmit-ack, abort-ack, receive-pending and remote-pending flags.
- R8: The per-register permit vector is all ones outside sleep. In sleep only bits 0 to 3 are set.
- R9: If both requests drop while the mode is pending, the mode returns to normal. Bus participation remains on, with no new recessive-run wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the mode register |
| sleep_req | input | 1 | Sleep request from the mode register |
| bus_idle | input | 1 | Bus idle indication from the bit engine |
| bus_ifs | input | 1 | Intermission indication from the bit engine |
| bit_stb | input | 1 | One-cycle strobe per sampled bit |
| rx_bit | input | 1 | Sampled bus bit, 1 = recessive |
| acc_sel | input | $clog2(NREG) | Register index of the current access |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| rdata_in | input | DW | Read data from the register file |
| mode_o | output | 2 | Current mode code |
| halt_st_o | output | 1 | Halt status bit |
| bus_en_o | output | 1 | Participate-on-bus enable |
| core_clk_en_o | output | 1 | Clock enable for the main controller logic |
| reg_permit_o | output | NREG | Per-register access permit |
| acc_rd_en_o | output | 1 | Read enable passed to the register file |
| acc_wr_en_o | output | 1 | Write enable passed to the register file |
| rdata_o | output | DW | Gated read data |
| acc_err_o | output | 1 | Pulse after a blocked access |

## Verification
The hardest states to reach from the ports are the cancelled pending case and the restart of the rejoin count. Both need the controller already joined, which takes a long run of recessive strobes first. The bench builds that joined state with directed strobe runs. It then holds halt or sleep while keeping both bus-idle and intermission low, which parks the mode in pending, before it drops the requests. The restart is exercised by placing a single dominant strobe one bit short of the full run. The bench then shows that ten further recessive bits are not enough and the eleventh is.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MD_RUN   = 2'b00,
    MD_PEND  = 2'b01,
    MD_HALT  = 2'b10,
    MD_SLEEP = 2'b11
  } mode_e;
endpackage

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt_req,
  input  logic  sleep_req,
  input  logic  bus_idle,
  input  logic  bus_ifs,
  input  logic  joined,
  output mode_e mode_o,
  output logic  rejoin_clr_o
);
  mode_e mode_q, mode_d;
  logic  safe, want;
  mode_e tgt;

  // a controller that has not joined the bus may stop at any time
  assign safe = bus_idle | bus_ifs | ~joined;
  assign want = halt_req | sleep_req;
  assign tgt  = sleep_req ? MD_SLEEP : MD_HALT;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MD_RUN: begin
        if (want) mode_d = safe ? tgt : MD_PEND;
      end
      MD_PEND: begin
        if (!want)     mode_d = MD_RUN;
        else if (safe) mode_d = tgt;
      end
      MD_HALT: begin
        if (sleep_req)     mode_d = MD_SLEEP;
        else if (!halt_req) mode_d = MD_RUN;
      end
      MD_SLEEP: begin
        if (!sleep_req) mode_d = halt_req ? MD_HALT : MD_RUN;
      end
      default: mode_d = MD_RUN;
    endcase
  end

  assign rejoin_clr_o = (mode_d == MD_RUN) &&
                        ((mode_q == MD_HALT) || (mode_q == MD_SLEEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_RUN;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_HALT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_HALT) && ($past(mode_q) == MD_RUN || $past(mode_q) == MD_PEND))
      |-> $past(bus_idle | bus_ifs | ~joined)); // R1

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_PEND) && want && !safe) |=> (mode_q == MD_PEND)); // R1

  AST_PEND_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_PEND) && !want) |=> (mode_q == MD_RUN)); // R9
endmodule

// File: rtl/can_rejoin_cnt.sv
module can_rejoin_cnt #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic done_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ld;

  assign done_o = (cnt_q == LAST);
  assign cnt_ld = clr | (en & bit_stb & ~done_o);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (rx_bit) cnt_d = cnt_q + CW'(1);
    else             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  AST_JOIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bit_stb && rx_bit && en)); // R4

  AST_DOM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_stb && !rx_bit && !clr && !done_o) |=> (cnt_q == '0)); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/can_acc_gate.sv
module can_acc_gate #(
  parameter int              NREG     = 16,
  parameter int              DW       = 32,
  parameter logic [NREG-1:0] AON_MASK = NREG'(4'hF),
  localparam int             AW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep,
  input  logic [AW-1:0]   acc_sel,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic [DW-1:0]   rdata_in,
  output logic [NREG-1:0] permit_o,
  output logic            rd_en_o,
  output logic            wr_en_o,
  output logic [DW-1:0]   rdata_o,
  output logic            err_o
);
  logic sel_ok, err_d, err_q;

  for (genvar g = 0; g < NREG; g++) begin : g_permit
    assign permit_o[g] = ~sleep | AON_MASK[g];
  end

  always_comb begin
    sel_ok = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (acc_sel == AW'(i)) sel_ok = permit_o[i];
  end

  assign rd_en_o = acc_rd & sel_ok;
  assign wr_en_o = acc_wr & sel_ok;
  assign rdata_o = sel_ok ? rdata_in : '0;
  assign err_d   = (acc_rd | acc_wr) & ~sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(sleep && (acc_rd || acc_wr))); // R7

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !rd_en_o) |-> (rdata_o == '0)); // R7
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int              NREG     = 16,
  parameter int              DW       = 32,
  parameter int              RUN_LEN  = 11,
  parameter logic [NREG-1:0] AON_MASK = NREG'(4'hF),
  localparam int             AW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            sleep_req,
  input  logic            bus_idle,
  input  logic            bus_ifs,
  input  logic            bit_stb,
  input  logic            rx_bit,
  input  logic [AW-1:0]   acc_sel,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic [DW-1:0]   rdata_in,
  output logic [1:0]      mode_o,
  output logic            halt_st_o,
  output logic            bus_en_o,
  output logic            core_clk_en_o,
  output logic [NREG-1:0] reg_permit_o,
  output logic            acc_rd_en_o,
  output logic            acc_wr_en_o,
  output logic [DW-1:0]   rdata_o,
  output logic            acc_err_o
);
  logic [1:0] rst_sync;
  logic       rst_ni;
  mode_e      mode;
  logic       joined, rejoin_clr, on_bus;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  can_mode_fsm i_fsm (
    .clk          (clk),
    .rst_n        (rst_ni),
    .halt_req     (halt_req),
    .sleep_req    (sleep_req),
    .bus_idle     (bus_idle),
    .bus_ifs      (bus_ifs),
    .joined       (joined),
    .mode_o       (mode),
    .rejoin_clr_o (rejoin_clr)
  );

  assign on_bus = (mode == MD_RUN) || (mode == MD_PEND);

  can_rejoin_cnt #(.RUN_LEN(RUN_LEN)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_ni),
    .en      (on_bus),
    .clr     (rejoin_clr),
    .bit_stb (bit_stb),
    .rx_bit  (rx_bit),
    .done_o  (joined)
  );

  can_acc_gate #(.NREG(NREG), .DW(DW), .AON_MASK(AON_MASK)) i_gate (
    .clk      (clk),
    .rst_n    (rst_ni),
    .sleep    (mode == MD_SLEEP),
    .acc_sel  (acc_sel),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .rdata_in (rdata_in),
    .permit_o (reg_permit_o),
    .rd_en_o  (acc_rd_en_o),
    .wr_en_o  (acc_wr_en_o),
    .rdata_o  (rdata_o),
    .err_o    (acc_err_o)
  );

  assign mode_o        = mode;
  assign halt_st_o     = (mode == MD_HALT);
  assign bus_en_o      = on_bus & joined;
  assign core_clk_en_o = (mode != MD_SLEEP);

  AST_REJOIN_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    ((mode == MD_RUN) && ($past(mode) == MD_HALT || $past(mode) == MD_SLEEP))
      |-> !bus_en_o); // R4

  AST_SLEEP_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_ni)
    ((mode == MD_HALT) && sleep_req) |=> (mode == MD_SLEEP)); // R5
endmodule

// File: tb/test_can_mode_seq.sv
module test_can_mode_seq;
  localparam int CLK_P = 10;
  localparam int NREG  = 16;
  localparam int DW    = 32;
  localparam int AW    = $clog2(NREG);
  localparam int NV    = 10;

  // {halt, sleep, idle, ifs, stb, rx, mode[1:0], bus_en, clk_en}
  localparam logic [9:0] VEC [NV] = '{
    10'b1000000111,  // R1 halt, bus busy -> pending
    10'b1000100111,  // R1 still busy, dominant strobe keeps joined
    10'b1001001001,  // R1 R3 intermission -> halted, off bus
    10'b1010001001,  // R2 stays halted
    10'b1100001100,  // R5 R6 sleep from halted
    10'b1000001001,  // R6 sleep release with halt -> halted
    10'b0000000001,  // R4 halt release -> normal, not yet joined
    10'b0000110001,  // R4 one recessive bit only
    10'b0100001100,  // R5 not joined counts as safe -> sleep
    10'b0000000001   // R6 sleep release -> normal
  };
  localparam int VREQ [NV] = '{1, 1, 1, 2, 5, 6, 4, 4, 5, 6};

  logic clk = 1'b0;
  logic rst_n, halt_req, sleep_req, bus_idle, bus_ifs, bit_stb, rx_bit;
  logic [AW-1:0] acc_sel;
  logic acc_rd, acc_wr;
  logic [DW-1:0] rdata_in;
  logic [1:0] mode_o;
  logic halt_st_o, bus_en_o, core_clk_en_o, acc_rd_en_o, acc_wr_en_o, acc_err_o;
  logic [NREG-1:0] reg_permit_o;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  can_mode_seq i_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .bus_idle(bus_idle), .bus_ifs(bus_ifs), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .acc_sel(acc_sel), .acc_rd(acc_rd), .acc_wr(acc_wr), .rdata_in(rdata_in),
    .mode_o(mode_o), .halt_st_o(halt_st_o), .bus_en_o(bus_en_o),
    .core_clk_en_o(core_clk_en_o), .reg_permit_o(reg_permit_o),
    .acc_rd_en_o(acc_rd_en_o), .acc_wr_en_o(acc_wr_en_o),
    .rdata_o(rdata_o), .acc_err_o(acc_err_o)
  );

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic s, input logic i,
                      input logic f, input logic b, input logic r);
    halt_req = h; sleep_req = s; bus_idle = i; bus_ifs = f;
    bit_stb = b; rx_bit = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic recessive(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; halt_req = 0; sleep_req = 0; bus_idle = 0; bus_ifs = 0;
    bit_stb = 0; rx_bit = 0; acc_sel = '0; acc_rd = 0; acc_wr = 0;
    rdata_in = 32'hA5A5_5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk(2, "reset mode", 32'(mode_o), 32'h0);
    chk(2, "reset halt status", 32'(halt_st_o), 32'h0);
    chk(4, "reset bus_en waits for run", 32'(bus_en_o), 32'h0);
    chk(6, "reset clk enable", 32'(core_clk_en_o), 32'h1);

    // R4 dominant bit one short of the run restarts it
    recessive(10);
    chk(4, "10 recessive not joined", 32'(bus_en_o), 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    recessive(10);
    chk(4, "restart after dominant", 32'(bus_en_o), 32'h0);
    recessive(1);
    chk(4, "joined after 11", 32'(bus_en_o), 32'h1);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      chk(VREQ[v], $sformatf("vec %0d mode", v), 32'(mode_o), 32'(VEC[v][3:2]));
      chk(VREQ[v], $sformatf("vec %0d bus_en", v), 32'(bus_en_o), 32'(VEC[v][1]));
      chk(VREQ[v], $sformatf("vec %0d clk_en", v), 32'(core_clk_en_o), 32'(VEC[v][0]));
      chk(2, $sformatf("vec %0d halt status", v), 32'(halt_st_o),
          32'(VEC[v][3:2] == 2'b10)); // R2
    end

    // R9 cancelled pending keeps the controller joined
    recessive(11);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(5, "sleep waits for safe point", 32'(mode_o), 32'h1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(9, "cancel -> normal", 32'(mode_o), 32'h0);
    chk(9, "cancel keeps bus_en", 32'(bus_en_o), 32'h1);

    // R5 priority of sleep over halt
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(5, "both requests -> sleep", 32'(mode_o), 32'h3);

    // R8 permit vector in sleep
    chk(8, "permit in sleep", 32'(reg_permit_o), 32'h000F);

    // R7 blocked flag register read
    acc_sel = AW'(5); acc_rd = 1'b1;
    #1;
    chk(7, "blocked read data", rdata_o, 32'h0);
    chk(7, "blocked read enable", 32'(acc_rd_en_o), 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(7, "error pulse", 32'(acc_err_o), 32'h1);
    // R7 always-on register write passes
    acc_rd = 1'b0; acc_sel = AW'(2); acc_wr = 1'b1;
    #1;
    chk(7, "aon write enable", 32'(acc_wr_en_o), 32'h1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(7, "no error on aon", 32'(acc_err_o), 32'h0);
    acc_wr = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(7, "error is one pulse", 32'(acc_err_o), 32'h0);

    // R6 leave sleep straight to normal, R8 permits restored
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(6, "sleep release -> normal", 32'(mode_o), 32'h0);
    chk(8, "permit outside sleep", 32'(reg_permit_o), 32'hFFFF);
    acc_sel = AW'(5); acc_rd = 1'b1;
    #1;
    chk(7, "flag read outside sleep", rdata_o, 32'hA5A5_5A5A);
    acc_rd = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule